// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits beside a two-wire bus master and frees a serial memory target that was left holding the data line low after an aborted transfer, a brown-out or a reset of the host. When it receives a request, it releases the data line and toggles the clock line through a limited series of pulses. In the last cycle of each clock-high phase it samples the data line. It stops clocking at the first pulse where the data line reads high.

With the line free, the block holds the clock high and issues a start condition: the data line stays released for a setup window and is then pulled low for a hold window. After that it returns both lines to the released state. If the data line is still low after the last permitted pulse, the block reports failure and issues no start. All phase lengths are counts of the system clock, so the same RTL covers any bus rate.

The clock line is driven as a level (`scl_o` = 1 means released high). The data line is open-drain: `sda_oe_o` = 1 pulls it low, and `sda_i` is the resolved line level.

Top module: `bus_recover`

## Requirements
- R1: After reset and while idle, `scl_o` is 1 and `sda_oe_o`, `busy_o`, `done_o` and `fail_o` are 0.
- R2: A cycle with `req_i` = 1 while idle starts a sequence. `busy_o` is 1 from the next cycle through the cycle of the `done_o` or `fail_o` pulse, and is 0 in the cycle after.
- R3: Each clock pulse is exactly `LOW_CYC` cycles of `scl_o` = 0 followed by `HIGH_CYC` cycles of `scl_o` = 1.
- R4: During the clock pulses `sda_oe_o` stays 0, so the data line is never driven while `scl_o` is 0.
- R5: `sda_i` is sampled in the last cycle of each high phase. If it reads 1 there, no further pulse follows, so the pulse count equals the index of the first pulse that sampled 1.
- R6: At most `MAX_PULSES` pulses are issued. If `sda_i` is still 0 at the end of the last one, `fail_o` pulses for one cycle and `sda_oe_o` is never asserted.
- R7: After a high sample, `scl_o` stays 1. `sda_oe_o` rises exactly `HIGH_CYC + SETUP_CYC` cycles after the final rise of `scl_o`, stays 1 for `HOLD_CYC` cycles, and then `done_o` pulses for one cycle with both lines released.
- R8: Requests that arrive while `busy_o` is 1 are ignored and do not change the timing of the running sequence.
- R9: Counting the cycle after the accepted request as cycle 0, `done_o` occurs in cycle n·(`LOW_CYC`+`HIGH_CYC`)+`SETUP_CYC`+`HOLD_CYC` for n pulses, and `fail_o` occurs in cycle `MAX_PULSES`·(`LOW_CYC`+`HIGH_CYC`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Recovery request, taken only while idle |
| sda_i | input | 1 | Resolved data line level |
| scl_o | output | 1 | Clock line level, 1 = released high |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: start issued |
| fail_o | output | 1 | One-cycle pulse: line still stuck after the last pulse |

## Verification
A phase timer that is off by one shows up as a wrong low or high run length on `scl_o`, and the error is visible at the end of the very first pulse. A pulse counter that advances on the wrong edge, or that compares against the wrong limit, moves the `done_o`/`fail_o` cycle by a whole pulse period, or produces a start where a failure was due. The bench sweeps the target's release point across every pulse index, including the cases just below and above the limit. A state decode that drives the data line too early appears as `sda_oe_o` high while `scl_o` is low, in that same cycle.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SETUP,
    ST_HOLD,
    ST_DONE,
    ST_FAIL
  } rec_state_e;
endpackage

// File: rtl/bus_recover_timer.sv
module bus_recover_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // expired timer stays expired until reloaded
  assert_timer_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/bus_recover_pcount.sv
module bus_recover_pcount #(
  parameter int MAX_PULSES = 9,
  parameter int PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [PW-1:0] cnt_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == PW'(MAX_PULSES));

  assert_pulse_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= PW'(MAX_PULSES));
endmodule

// File: rtl/bus_recover.sv
module bus_recover
  import bus_recover_pkg::*;
#(
  parameter int LOW_CYC    = 470,
  parameter int HIGH_CYC   = 400,
  parameter int SETUP_CYC  = 470,
  parameter int HOLD_CYC   = 400,
  parameter int MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int MAX_A = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_B = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int PW    = $clog2(MAX_PULSES + 1);

  rec_state_e    st_q, st_d;
  logic          t_zero, t_load, last_pulse;
  logic [CW-1:0] t_val;
  logic [PW-1:0] pcnt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i)  st_d = ST_LOW;
      ST_LOW:   if (t_zero) st_d = ST_HIGH;
      ST_HIGH:  if (t_zero) begin
                  if (sda_i)           st_d = ST_SETUP;
                  else if (last_pulse) st_d = ST_FAIL;
                  else                 st_d = ST_LOW;
                end
      ST_SETUP: if (t_zero) st_d = ST_HOLD;
      ST_HOLD:  if (t_zero) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      ST_FAIL:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_LOW:   t_val = CW'(LOW_CYC - 1);
      ST_HIGH:  t_val = CW'(HIGH_CYC - 1);
      ST_SETUP: t_val = CW'(SETUP_CYC - 1);
      ST_HOLD:  t_val = CW'(HOLD_CYC - 1);
      default:  t_val = '0;
    endcase
  end

  assign t_load = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  bus_recover_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  bus_recover_pcount #(.MAX_PULSES(MAX_PULSES), .PW(PW)) u_pcount (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == ST_IDLE && req_i),
    .inc_i  (st_q == ST_LOW && st_d == ST_HIGH),
    .cnt_o  (pcnt),
    .last_o (last_pulse)
  );

  assign scl_o    = (st_q != ST_LOW);
  assign sda_oe_o = (st_q == ST_HOLD);
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_DONE);
  assign fail_o   = (st_q == ST_FAIL);

  assert_fail_at_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (pcnt == PW'(MAX_PULSES)));

  assert_start_scl_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (scl_o && $past(scl_o)));

  assert_done_after_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(sda_oe_o));

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !fail_o) |=> busy_o);
endmodule

// File: tb/bus_recover_test.sv
module bus_recover_test;
  localparam int L = 3;
  localparam int H = 2;
  localparam int S = 4;
  localparam int D = 3;
  localparam int M = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic scl, sda_oe, busy, done, fail;
  logic tgt_low = 1'b0;
  logic sda;

  int total = 0, bad = 0;
  int mon_total = 0, mon_bad = 0;
  int wd_bad = 0;
  int k_rel = 0;
  int rises = 0, run = 0, hold_cnt = 0, cs = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0, seen_low = 1'b0;

  always #5 clk = ~clk;

  assign sda = ~sda_oe & ~tgt_low;

  bus_recover #(.LOW_CYC(L), .HIGH_CYC(H), .SETUP_CYC(S), .HOLD_CYC(D),
                .MAX_PULSES(M)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sda_i(sda),
    .scl_o(scl), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // line monitor: target model, run lengths, start placement
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy) begin
        rises = 0; seen_low = 1'b0; hold_cnt = 0; cs = 0;
      end
      if (scl != prev_scl) begin
        if (!prev_scl) begin
          mon_total++;
          if (run != L) begin mon_bad++; $display("FAIL R3 low run actual=%0d expected=%0d", run, L); end
          rises++; cs = 0;
        end else begin
          if (seen_low) begin
            mon_total++;
            if (run != H) begin mon_bad++; $display("FAIL R3 high run actual=%0d expected=%0d", run, H); end
          end
          seen_low = 1'b1;
        end
        run = 1;
      end else begin
        run++;
        cs++;
      end
      if (sda_oe && !scl) begin
        mon_total++; mon_bad++;
        $display("FAIL R4 sda driven with scl low actual=1 expected=0");
      end
      if (sda_oe && !prev_oe) begin
        mon_total++;
        if (cs != H + S) begin mon_bad++; $display("FAIL R7 setup actual=%0d expected=%0d", cs, H + S); end
      end
      if (sda_oe) hold_cnt++;
      prev_scl = scl;
      prev_oe  = sda_oe;
      tgt_low  = (rises < k_rel);
    end
  end

  task automatic run_case(input int k);
    int n, j, exp_j;
    bit ok_end;
    k_rel = k;
    @(negedge clk);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R2", busy, 1);
    n = (k < 1) ? 1 : k;
    j = 0;
    ok_end = 1'b0;
    while (j < 1000 && !ok_end) begin
      if (done || fail) ok_end = 1'b1;
      else begin
        if (j == 2) req = 1'b1;   // R8: request while busy
        if (j == 3) req = 1'b0;
        j++;
        @(negedge clk);
      end
    end
    if (n <= M) begin
      exp_j = n * (L + H) + S + D;
      check(done && !fail, "R7", done, 1);
      check(j == exp_j, "R9 R8", j, exp_j);
      check(rises == n, "R5", rises, n);
      check(hold_cnt == D, "R7", hold_cnt, D);
    end else begin
      exp_j = M * (L + H);
      check(fail && !done, "R6", fail, 1);
      check(j == exp_j, "R9 R8", j, exp_j);
      check(rises == M, "R6", rises, M);
      check(hold_cnt == 0, "R6", hold_cnt, 0);
    end
    check(busy == 1'b1, "R2", busy, 1);
    @(negedge clk);
    check(!busy && !done && !fail && scl && !sda_oe, "R2 R7", {busy, done, fail, scl, sda_oe}, 5'b00010);
  endtask

  task automatic finish_up();
    total = total + mon_total + wd_bad;
    bad   = bad + mon_bad + wd_bad;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl && !sda_oe && !busy && !done && !fail, "R1", {scl, sda_oe, busy, done, fail}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl && !sda_oe && !busy && !done && !fail, "R1", {scl, sda_oe, busy, done, fail}, 5'b10000);
    for (int k = 0; k <= M + 2; k++) run_case(k);
    run_case(50);
    run_case(1);
    finish_up();
  end
endmodule